// File: doc/BRIEF.md
# Stack Frame Sequencer

This block owns an 8-bit stack pointer and moves the byte frames that a small processor core needs for subroutine calls and returns, software breaks, interrupt returns, and single-register saves and restores. The core issues one command together with its current 16-bit program counter, status byte and accumulator. The sequencer then drives a byte-wide memory port for one byte per cycle until the frame is complete. Every stack access falls in one fixed 256-byte page. Memory reads are combinational: data must be valid in the same cycle as the address.

When a frame finishes, the sequencer raises a one-cycle done strobe. The values it recovered (program counter, status and accumulator) are then held on its result outputs. While a frame is in flight the block reports busy and ignores any command presented to it. Instruction fetch, decode, vector fetch and the memory array are outside the block.

Top module: `stack_seq`

## Requirements
- R1: While reset is held, `sp` is 0xFF, `busy` and `done` are 0, and `pc_out`, `status_out` and `acc_out` are 0.
- R2: A push cycle writes the byte to address {0x01, sp} and then decrements `sp` by one. Every stack access drives 0x01 on the upper address byte.
- R3: A pull cycle first increments `sp` and then reads the byte at {0x01, sp+1}.
- R4: Command 1 (call) pushes the program counter high byte, then the low byte. It takes two cycles and leaves `sp` lowered by 2.
- R5: Command 2 (break) pushes three bytes in this order: the high byte of (PC+2) modulo 65536, its low byte, then the status byte with bit 4 forced to 1. `pc_out` becomes PC+2 and `status_out` becomes the status with bit 4 set.
- R6: Command 3 (interrupt return) pulls three bytes in this order: the status byte, the PC low byte, then the PC high byte. They appear on `status_out` and `pc_out`.
- R7: Command 4 (subroutine return) pulls the PC low byte, then the PC high byte, onto `pc_out` and leaves `status_out` unchanged.
- R8: The single-byte commands are 5 (push accumulator), 6 (push status), 7 (pull into `acc_out`) and 8 (pull into `status_out`).
- R9: The stack pointer wraps modulo 256 in both directions. A pull at 0xFF reads address 0x0100, and a push at 0x00 leaves `sp` at 0xFF.
- R10: After a command of N bytes is accepted, `busy` is high for exactly N cycles, with one byte moved per cycle. `done` is high for one cycle, immediately after the last byte, while `busy` is low.
- R11: Commands presented while `busy` is high have no effect. Codes 0 and 9 to 15 are never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd | input | 4 | Operation code |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status byte |
| acc_in | input | 8 | Current accumulator |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the same cycle |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion strobe |
| pc_out | output | 16 | Restored or advanced program counter |
| status_out | output | 8 | Restored or break status |
| acc_out | output | 8 | Restored accumulator |

## Verification
A pointer that is stepped in the wrong direction, or stepped at the wrong moment, sends the next access to the wrong address. That mismatch is visible on `mem_addr` in the very next cycle, and it also appears in `sp` once the frame is complete. A wrong byte slot or a wrong destination select does not show up at once. It shows only when the frame is pulled back: after the matching return, at the `done` strobe, `pc_out`, `status_out` or `acc_out` disagree with the model. A fault in the busy/done counting shows as a strobe that arrives off the expected cycle, or as a command that was accepted while the block was busy and so shifts the pointer.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
  localparam int FRAME_MAX  = 3;
  localparam int CNT_W      = $clog2(FRAME_MAX + 1);
  localparam int BRK_BIT    = 4;
  localparam logic [7:0] BRK_MASK = 8'(1 << BRK_BIT);

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_CALL     = 4'd1,
    OP_BREAK    = 4'd2,
    OP_RET_INT  = 4'd3,
    OP_RET_SUB  = 4'd4,
    OP_PUSH_ACC = 4'd5,
    OP_PUSH_ST  = 4'd6,
    OP_PULL_ACC = 4'd7,
    OP_PULL_ST  = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    DST_NONE = 3'd0,
    DST_PCL  = 3'd1,
    DST_PCH  = 3'd2,
    DST_ST   = 3'd3,
    DST_ACC  = 3'd4
  } dst_e;
endpackage

// File: rtl/stk_frame.sv
`timescale 1ns/1ps
module stk_frame
  import stk_pkg::*;
(
  input  logic [3:0]  op,
  input  logic [15:0] pc,
  input  logic [7:0]  st,
  input  logic [7:0]  acc,
  output logic        f_ok,
  output logic        f_pull,
  output logic [CNT_W-1:0] f_cnt,
  output logic [FRAME_MAX-1:0][7:0] f_byte,
  output dst_e        f_dst [FRAME_MAX]
);
  logic [15:0] pc_adv;
  assign pc_adv = pc + 16'd2;

  always_comb begin
    f_ok   = 1'b1;
    f_pull = 1'b0;
    f_cnt  = '0;
    f_byte = '0;
    for (int k = 0; k < FRAME_MAX; k++) f_dst[k] = DST_NONE;
    case (op)
      OP_CALL: begin
        f_cnt = CNT_W'(2);
        f_byte[0] = pc[15:8];
        f_byte[1] = pc[7:0];
      end
      OP_BREAK: begin
        f_cnt = CNT_W'(3);
        f_byte[0] = pc_adv[15:8];
        f_byte[1] = pc_adv[7:0];
        f_byte[2] = st | BRK_MASK;
      end
      OP_RET_INT: begin
        f_cnt  = CNT_W'(3);
        f_pull = 1'b1;
        f_dst[0] = DST_ST;
        f_dst[1] = DST_PCL;
        f_dst[2] = DST_PCH;
      end
      OP_RET_SUB: begin
        f_cnt  = CNT_W'(2);
        f_pull = 1'b1;
        f_dst[0] = DST_PCL;
        f_dst[1] = DST_PCH;
      end
      OP_PUSH_ACC: begin
        f_cnt = CNT_W'(1);
        f_byte[0] = acc;
      end
      OP_PUSH_ST: begin
        f_cnt = CNT_W'(1);
        f_byte[0] = st;
      end
      OP_PULL_ACC: begin
        f_cnt  = CNT_W'(1);
        f_pull = 1'b1;
        f_dst[0] = DST_ACC;
      end
      OP_PULL_ST: begin
        f_cnt  = CNT_W'(1);
        f_pull = 1'b1;
        f_dst[0] = DST_ST;
      end
      default: f_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/stk_ptr.sv
`timescale 1ns/1ps
module stk_ptr #(
  parameter logic [7:0] SP_INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_en,
  input  logic       dec_en,
  output logic [7:0] sp_q,
  output logic [7:0] sp_up
);
  logic [7:0] sp_d;

  assign sp_up = sp_q + 8'd1;

  always_comb begin
    sp_d = sp_q;
    if (inc_en)      sp_d = sp_up;
    else if (dec_en) sp_d = sp_q - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_INIT;
    else        sp_q <= sp_d;
  end
endmodule

// File: rtl/stk_result.sv
`timescale 1ns/1ps
module stk_result
  import stk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  dst_e        cap_dst,
  input  logic [7:0]  cap_data,
  input  logic        pre_en,
  input  logic [15:0] pre_pc,
  input  logic [7:0]  pre_st,
  output logic [15:0] pc_q,
  output logic [7:0]  st_q,
  output logic [7:0]  acc_q
);
  logic [15:0] pc_d;
  logic [7:0]  st_d;
  logic [7:0]  acc_d;

  always_comb begin
    pc_d  = pc_q;
    st_d  = st_q;
    acc_d = acc_q;
    if (pre_en) begin
      pc_d = pre_pc;
      st_d = pre_st;
    end
    if (cap_en) begin
      case (cap_dst)
        DST_PCL: pc_d[7:0]  = cap_data;
        DST_PCH: pc_d[15:8] = cap_data;
        DST_ST:  st_d       = cap_data;
        DST_ACC: acc_d      = cap_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      st_q  <= '0;
      acc_q <= '0;
    end else begin
      pc_q  <= pc_d;
      st_q  <= st_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/stack_seq.sv
`timescale 1ns/1ps
module stack_seq
  import stk_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] SP_INIT    = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [3:0]  cmd,
  input  logic [15:0] pc_in,
  input  logic [7:0]  status_in,
  input  logic [7:0]  acc_in,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  sp,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [7:0]  status_out,
  output logic [7:0]  acc_out
);
  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  // frame decode
  logic                        f_ok, f_pull;
  logic [CNT_W-1:0]            f_cnt;
  logic [FRAME_MAX-1:0][7:0]   f_byte;
  dst_e                        f_dst [FRAME_MAX];

  stk_frame u_frame (
    .op     (cmd),
    .pc     (pc_in),
    .st     (status_in),
    .acc    (acc_in),
    .f_ok   (f_ok),
    .f_pull (f_pull),
    .f_cnt  (f_cnt),
    .f_byte (f_byte),
    .f_dst  (f_dst)
  );

  // sequencer state
  logic             act_q, act_d;
  logic             pull_q, pull_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             accept, last_step;

  logic [7:0] slot_byte [FRAME_MAX];
  dst_e       slot_dst  [FRAME_MAX];

  for (genvar g = 0; g < FRAME_MAX; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
        slot_byte[g] <= '0;
        slot_dst[g]  <= DST_NONE;
      end else if (accept) begin
        slot_byte[g] <= f_byte[g];
        slot_dst[g]  <= f_dst[g];
      end
    end
  end

  always_comb begin
    accept    = cmd_valid && !act_q && f_ok;
    last_step = act_q && (idx_q == cnt_q - CNT_W'(1));
    act_d     = act_q;
    pull_d    = pull_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    if (accept) begin
      act_d  = 1'b1;
      pull_d = f_pull;
      idx_d  = '0;
      cnt_d  = f_cnt;
    end else if (act_q) begin
      idx_d = idx_q + CNT_W'(1);
      if (last_step) act_d = 1'b0;
    end
    done_d = last_step;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      act_q  <= 1'b0;
      pull_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      pull_q <= pull_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // pointer
  logic [7:0] sp_q, sp_up;
  logic       do_push, do_pull;
  assign do_push = act_q && !pull_q;
  assign do_pull = act_q && pull_q;

  stk_ptr #(.SP_INIT(SP_INIT)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .inc_en (do_pull),
    .dec_en (do_push),
    .sp_q   (sp_q),
    .sp_up  (sp_up)
  );

  // current slot
  logic [7:0] cur_byte;
  dst_e       cur_dst;
  always_comb begin
    cur_byte = '0;
    cur_dst  = DST_NONE;
    for (int k = 0; k < FRAME_MAX; k++) begin
      if (idx_q == CNT_W'(k)) begin
        cur_byte = slot_byte[k];
        cur_dst  = slot_dst[k];
      end
    end
  end

  // results
  logic        pre_en;
  logic [15:0] pre_pc;
  logic [7:0]  pre_st;
  assign pre_en = accept && (cmd == OP_BREAK);
  assign pre_pc = pc_in + 16'd2;
  assign pre_st = status_in | BRK_MASK;

  stk_result u_res (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cap_en   (do_pull),
    .cap_dst  (cur_dst),
    .cap_data (mem_rdata),
    .pre_en   (pre_en),
    .pre_pc   (pre_pc),
    .pre_st   (pre_st),
    .pc_q     (pc_out),
    .st_q     (status_out),
    .acc_q    (acc_out)
  );

  // memory port
  assign mem_we    = do_push;
  assign mem_re    = do_pull;
  assign mem_addr  = {STACK_PAGE, (pull_q ? sp_up : sp_q)};
  assign mem_wdata = do_push ? cur_byte : 8'h00;
  assign sp        = sp_q;
  assign busy      = act_q;
  assign done      = done_q;
endmodule

// File: rtl/stk_seq_chk.sv
`timescale 1ns/1ps
module stk_seq_chk #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic        mem_re,
  input logic [7:0]  sp,
  input logic        busy,
  input logic        done
);
  a_r2_push_lowers_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - 8'd1));

  a_r3_pull_raises_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp == $past(sp) + 8'd1));

  a_r2_write_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[7:0] == sp));

  a_r3_read_above_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr[7:0] == sp + 8'd1));

  a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_addr[15:8] == STACK_PAGE));

  a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}) && ((mem_we || mem_re) == busy));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_sp_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sp));
endmodule

bind stack_seq stk_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .sp       (sp),
  .busy     (busy),
  .done     (done)
);

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd;
  logic [15:0] pc_in;
  logic [7:0]  status_in, acc_in;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  sp;
  logic        busy, done;
  logic [15:0] pc_out;
  logic [7:0]  status_out, acc_out;

  int n_chk = 0;
  int n_fail = 0;
  int bad_page = 0;

  logic [7:0]  mem     [256];
  logic [7:0]  exp_mem [256];
  logic [7:0]  exp_sp;
  logic [15:0] exp_pc;
  logic [7:0]  exp_st, exp_acc;

  always #5 clk = ~clk;

  stack_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .pc_in(pc_in), .status_in(status_in), .acc_in(acc_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp(sp),
    .busy(busy), .done(done), .pc_out(pc_out),
    .status_out(status_out), .acc_out(acc_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_addr[15:8] != 8'h01) bad_page++;
    end
    if (mem_re && mem_addr[15:8] != 8'h01) bad_page++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mpush(input logic [7:0] v);
    exp_mem[exp_sp] = v;
    exp_sp = exp_sp - 8'd1;
  endtask

  task automatic mpull(output logic [7:0] v);
    exp_sp = exp_sp + 8'd1;
    v = exp_mem[exp_sp];
  endtask

  task automatic do_cmd(input logic [3:0] c, input logic [15:0] pc,
                        input logic [7:0] st, input logic [7:0] acc, input bit junk);
    int n;
    int mism;
    string req;
    logic [7:0] lo, hi, b;
    logic [15:0] p2;
    n = 0;
    req = "R11 bad code";
    case (c)
      4'd1: begin req = "R4 call"; mpush(pc[15:8]); mpush(pc[7:0]); n = 2; end
      4'd2: begin
        req = "R5 break"; p2 = pc + 16'd2;
        mpush(p2[15:8]); mpush(p2[7:0]); mpush(st | 8'h10);
        exp_pc = p2; exp_st = st | 8'h10; n = 3;
      end
      4'd3: begin
        req = "R6 int return";
        mpull(b); exp_st = b; mpull(lo); mpull(hi); exp_pc = {hi, lo}; n = 3;
      end
      4'd4: begin req = "R7 sub return"; mpull(lo); mpull(hi); exp_pc = {hi, lo}; n = 2; end
      4'd5: begin req = "R8 push acc"; mpush(acc); n = 1; end
      4'd6: begin req = "R8 push status"; mpush(st); n = 1; end
      4'd7: begin req = "R8 pull acc"; mpull(b); exp_acc = b; n = 1; end
      4'd8: begin req = "R8 pull status"; mpull(b); exp_st = b; n = 1; end
      default: n = 0;
    endcase
    cmd_valid = 1'b1; cmd = c; pc_in = pc; status_in = st; acc_in = acc;
    @(negedge clk);
    if (n == 0) begin
      cmd_valid = 1'b0;
      chk("R11 ignored code busy", {31'd0, busy}, 32'd0);
      chk("R11 ignored code sp", {24'd0, sp}, {24'd0, exp_sp});
      return;
    end
    chk({"R10 busy after accept ", req}, {31'd0, busy}, 32'd1);
    cmd_valid = junk;
    cmd = 4'($urandom_range(1, 8));
    pc_in = 16'($urandom); status_in = 8'($urandom); acc_in = 8'($urandom);
    repeat (n - 1) begin
      @(negedge clk);
      chk("R10 busy during frame", {31'd0, busy}, 32'd1);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({"R10 done strobe ", req}, {30'd0, done, busy}, 32'd2);
    chk({"R11 sp after frame ", req}, {24'd0, sp}, {24'd0, exp_sp});
    chk({req, " pc_out"}, {16'd0, pc_out}, {16'd0, exp_pc});
    chk({req, " status_out"}, {24'd0, status_out}, {24'd0, exp_st});
    chk({req, " acc_out"}, {24'd0, acc_out}, {24'd0, exp_acc});
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk({"R2 stack page image ", req}, mism, 0);
    @(negedge clk);
    chk("R10 done lasts one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17C3));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd = '0;
    pc_in = '0; status_in = '0; acc_in = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    exp_sp = 8'hFF; exp_pc = '0; exp_st = '0; exp_acc = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset sp", {24'd0, sp}, 32'h0000_00FF);
    chk("R1 reset busy/done", {30'd0, busy, done}, 32'd0);
    chk("R1 reset pc_out", {16'd0, pc_out}, 32'd0);
    chk("R1 reset status/acc", {16'd0, status_out, acc_out}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: pull from 0xFF wraps to page offset 0x00, push at 0x00 wraps back
    do_cmd(4'd7, 16'h0000, 8'h00, 8'h00, 1'b0);
    chk("R9 wrap pull reads offset 00", {24'd0, acc_out}, {24'd0, 8'd3});
    do_cmd(4'd5, 16'h0000, 8'h00, 8'h5A, 1'b1);
    chk("R9 wrap push sp", {24'd0, sp}, 32'h0000_00FF);
    do_cmd(4'd1, 16'h1234, 8'h00, 8'h00, 1'b1);
    do_cmd(4'd4, 16'h0000, 8'hC3, 8'h00, 1'b1);
    chk("R7 return restores pc", {16'd0, pc_out}, 32'h0000_1234);
    do_cmd(4'd2, 16'hFFFF, 8'h00, 8'h00, 1'b1);
    chk("R5 break pc wraps", {16'd0, pc_out}, 32'h0000_0001);
    do_cmd(4'd3, 16'h0000, 8'h00, 8'h00, 1'b0);
    chk("R6 status restored with B", {24'd0, status_out}, 32'h0000_0010);
    do_cmd(4'd6, 16'h0000, 8'hA5, 8'h00, 1'b1);
    do_cmd(4'd8, 16'h0000, 8'h00, 8'h00, 1'b0);
    chk("R8 pull status", {24'd0, status_out}, 32'h0000_00A5);
    do_cmd(4'd0, 16'h0000, 8'h00, 8'h00, 1'b0);
    do_cmd(4'd9, 16'h0000, 8'h00, 8'h00, 1'b0);
    do_cmd(4'd15, 16'h0000, 8'h00, 8'h00, 1'b0);

    for (int it = 0; it < 400; it++) begin
      logic [3:0] c;
      c = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15))
                                       : 4'($urandom_range(1, 8));
      do_cmd(c, 16'($urandom), 8'($urandom), 8'($urandom), bit'($urandom_range(0, 1)));
    end
    chk("R2 every access on page 01", bad_page, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule